// File: doc/BRIEF.md
# Eight-Bit Multicycle Processor Core

This block is a small processor with eight 8-bit general registers and a private 256-byte program memory. Each instruction takes two cycles. In the first cycle the core latches the opcode byte at the program counter and the two bytes that follow it. In the second cycle it decodes and executes them. The supported operations are immediate load, register output, add, multiply, unsigned compare, unconditional jump, and two conditional jumps driven by a three-bit one-hot compare flag.

Stack operations (push, pop, call, return) are not executed in the core. The core hands them to an attached stack unit through a one-cycle request, then waits for that unit's acknowledge. Programs are written into memory through a byte write port, which is accepted only while reset is held low. Executing begins at address 0 when reset is released.

The core decodes the instruction length from opcode bits [7:6], as that field plus one. Opcode bit 4 marks instructions that own the program counter. Any opcode outside the supported set stops the core and raises a sticky illegal-opcode flag.

Top module: `cpu8_core`

## Requirements
- R1: While rst_n is low, out_valid, halted, illegal and stk_req are 0, and a byte on prog_data with prog_we high is stored at prog_addr. After release, execution starts at address 0.
- R2: LDI (0x82) writes byte B into register A[2:0]. PRN (0x47) raises out_valid for exactly one cycle, with register A[2:0] on out_data.
- R3: ADD (0xA0) and MUL (0xA2) write the low 8 bits of rA+rB and rA*rB into rA.
- R4: CMP (0xA7) compares rA and rB unsigned and sets the flag to 3'b100 (less), 3'b010 (greater) or 3'b001 (equal). JEQ (0x55) jumps to rA only when the flag is 3'b001. JNE (0x56) jumps to rA only when it is not 3'b001.
- R5: JMP (0x54) loads the program counter from register A[2:0].
- R6: When opcode bit 4 is clear, and for a jump that is not taken, the program counter advances by opcode[7:6]+1 bytes.
- R7: HLT (0x01) sets halted. From then on the program counter is frozen and no further output appears.
- R8: An unsupported opcode sets both halted and illegal, and both stay set until reset.
- R9: PUSH (0x45), POP (0x46), CALL (0x50) and RET (0x11) each raise stk_req for one cycle. The request carries the opcode on stk_op, register A on stk_val, and PC+length on stk_ret. The core then waits for stk_ack. On stk_ack, stk_wr writes stk_wdata into register A, and the PC becomes stk_pc if opcode bit 4 is set, or PC+length otherwise.
- R10: Each CMP replaces the whole flag, so a later CMP fully overrides the result of an earlier one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; program loading window |
| prog_we | input | 1 | Program byte write strobe (honoured only in reset) |
| prog_addr | input | 8 | Program byte address |
| prog_data | input | 8 | Program byte value |
| out_valid | output | 1 | One-cycle strobe for a register output |
| out_data | output | 8 | Register value being output |
| halted | output | 1 | Core has stopped |
| illegal | output | 1 | Sticky unsupported-opcode flag |
| stk_req | output | 1 | One-cycle request to the stack unit |
| stk_op | output | 8 | Stack opcode being requested |
| stk_val | output | 8 | Value of register A |
| stk_ret | output | 8 | Address of the next instruction |
| stk_ack | input | 1 | Stack unit has finished the request |
| stk_wr | input | 1 | Write stk_wdata into register A on acknowledge |
| stk_wdata | input | 8 | Data for register A |
| stk_pc | input | 8 | New program counter for PC-owning stack opcodes |

## Verification
Register, flag and program counter contents are visible only through the output strobe, so the tests are written as small programs that end in PRN and HLT. A wrong register value appears in the next printed byte. A wrong flag or a misdecoded length sends execution down the other branch or into stray bytes. Either shows up as a missing or wrong print, or as the illegal flag, within a few instructions. Stack handoffs are checked through a behavioural stack unit in the bench. A push/pop round trip and a call/return are then observed through their printed values.

// File: rtl/cpu8_core.sv
module cpu8_core (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       prog_we,
  input  logic [7:0] prog_addr,
  input  logic [7:0] prog_data,
  output logic       out_valid,
  output logic [7:0] out_data,
  output logic       halted,
  output logic       illegal,
  output logic       stk_req,
  output logic [7:0] stk_op,
  output logic [7:0] stk_val,
  output logic [7:0] stk_ret,
  input  logic       stk_ack,
  input  logic       stk_wr,
  input  logic [7:0] stk_wdata,
  input  logic [7:0] stk_pc
);
  localparam logic [7:0] OP_HLT = 8'h01, OP_LDI = 8'h82, OP_PRN = 8'h47,
                         OP_ADD = 8'hA0, OP_MUL = 8'hA2, OP_CMP = 8'hA7,
                         OP_JMP = 8'h54, OP_JEQ = 8'h55, OP_JNE = 8'h56,
                         OP_PSH = 8'h45, OP_POP = 8'h46, OP_CAL = 8'h50,
                         OP_RET = 8'h11;
  localparam logic [2:0] FL_EQ = 3'b001;

  typedef enum logic [1:0] {S_FETCH, S_EXEC, S_STK, S_HALT} state_t;

  state_t     state;
  logic [7:0] mem [256];
  logic [7:0] regs [8];
  logic [7:0] pc, ir, opa, opb;
  logic [2:0] flags;

  always_ff @(posedge clk)
    if (!rst_n && prog_we) mem[prog_addr] <= prog_data;

  wire [2:0]  ra      = opa[2:0];
  wire [7:0]  va      = regs[ra];
  wire [7:0]  vb      = regs[opb[2:0]];
  wire [7:0]  pc_next = pc + {6'd0, ir[7:6]} + 8'd1;
  wire [15:0] prod    = {8'd0, va} * {8'd0, vb};

  assign stk_op  = ir;
  assign stk_val = va;
  assign stk_ret = pc_next;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_FETCH;
      pc        <= '0;
      ir        <= '0;
      opa       <= '0;
      opb       <= '0;
      flags     <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
      halted    <= 1'b0;
      illegal   <= 1'b0;
      stk_req   <= 1'b0;
      for (int i = 0; i < 8; i++) regs[i] <= '0;
    end else begin
      out_valid <= 1'b0;
      stk_req   <= 1'b0;
      case (state)
        S_FETCH: begin
          ir    <= mem[pc];
          opa   <= mem[pc + 8'd1];
          opb   <= mem[pc + 8'd2];
          state <= S_EXEC;
        end
        S_EXEC: begin
          state <= S_FETCH;
          pc    <= ir[4] ? pc : pc_next;
          case (ir)
            OP_LDI: regs[ra] <= opb;
            OP_PRN: begin out_valid <= 1'b1; out_data <= va; end
            OP_ADD: regs[ra] <= va + vb;
            OP_MUL: regs[ra] <= prod[7:0];
            OP_CMP: flags <= (va < vb) ? 3'b100 : (va > vb) ? 3'b010 : 3'b001;
            OP_JMP: pc <= va;
            OP_JEQ: pc <= (flags == FL_EQ) ? va : pc_next;
            OP_JNE: pc <= (flags != FL_EQ) ? va : pc_next;
            OP_HLT: begin halted <= 1'b1; state <= S_HALT; pc <= pc; end
            OP_PSH, OP_POP, OP_CAL, OP_RET: begin
              stk_req <= 1'b1;
              state   <= S_STK;
              pc      <= pc;
            end
            default: begin
              halted  <= 1'b1;
              illegal <= 1'b1;
              state   <= S_HALT;
              pc      <= pc;
            end
          endcase
        end
        S_STK:
          if (stk_ack) begin
            if (stk_wr) regs[ra] <= stk_wdata;
            pc    <= ir[4] ? stk_pc : pc_next;
            state <= S_FETCH;
          end
        default: ;
      endcase
    end
  end

  assert_prn_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  assert_halt_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> (halted && $stable(pc) && !out_valid));
  assert_illegal_halts_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> halted);
  assert_illegal_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> illegal);
  assert_stk_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stk_req |=> !stk_req);
endmodule

// File: tb/cpu8_core_tb.sv
module cpu8_core_tb;
  logic clk = 1'b0, rst_n = 1'b0;
  logic prog_we = 1'b0;
  logic [7:0] prog_addr = '0, prog_data = '0;
  logic out_valid, halted, illegal, stk_req;
  logic [7:0] out_data, stk_op, stk_val, stk_ret;
  logic stk_ack = 1'b0, stk_wr = 1'b0;
  logic [7:0] stk_wdata = '0, stk_pc = '0;

  int checks = 0, errors = 0, cycles = 0;
  logic [7:0] img [256];
  logic [7:0] cap [16];
  int ncap;
  logic [7:0] smem [256];
  int sp = 8'hF4;

  always #4 clk = ~clk;

  cpu8_core u_dut (.clk, .rst_n, .prog_we, .prog_addr, .prog_data,
    .out_valid, .out_data, .halted, .illegal, .stk_req, .stk_op, .stk_val,
    .stk_ret, .stk_ack, .stk_wr, .stk_wdata, .stk_pc);

  always @(posedge clk)
    if (!rst_n) ncap <= 0;
    else if (out_valid && ncap < 16) begin cap[ncap] <= out_data; ncap <= ncap + 1; end

  always @(posedge clk) begin
    stk_ack <= 1'b0;
    stk_wr  <= 1'b0;
    if (stk_req) begin
      case (stk_op)
        8'h45: begin sp = (sp - 1) & 255; smem[sp] = stk_val; end
        8'h46: begin stk_wdata <= smem[sp]; stk_wr <= 1'b1; sp = (sp + 1) & 255; end
        8'h50: begin sp = (sp - 1) & 255; smem[sp] = stk_ret; stk_pc <= stk_val; end
        8'h11: begin stk_pc <= smem[sp]; sp = (sp + 1) & 255; end
        default: ;
      endcase
      stk_ack <= 1'b1;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic run_prog(input int n);
    int t;
    rst_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      prog_we = 1'b1; prog_addr = i[7:0]; prog_data = img[i];
    end
    @(negedge clk);
    prog_we = 1'b0;
    rst_n = 1'b1;
    t = 0;
    while (!halted && t < 3000) begin @(negedge clk); t++; end
    check(halted, "R7 run reaches halt", halted, 1);
    repeat (3) @(negedge clk);
  endtask

  localparam logic [31:0] VEC [9] = '{
    {8'hA0, 8'd3,   8'd4,   8'd7},
    {8'hA0, 8'd200, 8'd100, 8'd44},
    {8'hA2, 8'd6,   8'd7,   8'd42},
    {8'hA2, 8'd16,  8'd17,  8'd16},
    {8'h55, 8'd5,   8'd5,   8'd1},
    {8'h55, 8'd3,   8'd9,   8'd0},
    {8'h56, 8'd9,   8'd3,   8'd1},
    {8'h56, 8'd2,   8'd8,   8'd1},
    {8'h56, 8'd4,   8'd4,   8'd0}
  };

  initial begin
    repeat (2) @(negedge clk);
    check(!out_valid && !halted && !illegal && !stk_req, "R1 reset outputs",
          {out_valid, halted, illegal, stk_req}, 0);

    for (int v = 0; v < 9; v++) begin
      logic [7:0] op, a, b, e;
      {op, a, b, e} = VEC[v];
      if (op[7]) begin
        img[0]=8'h82; img[1]=8'h01; img[2]=a;
        img[3]=8'h82; img[4]=8'h02; img[5]=b;
        img[6]=op;    img[7]=8'h01; img[8]=8'h02;
        img[9]=8'h47; img[10]=8'h01; img[11]=8'h01;
        run_prog(12);
        check(ncap == 1 && cap[0] == e, "R3 R2 R6 arithmetic vector", cap[0], e);
      end else begin
        img[0]=8'h82; img[1]=8'h01; img[2]=a;
        img[3]=8'h82; img[4]=8'h02; img[5]=b;
        img[6]=8'h82; img[7]=8'h03; img[8]=8'd20;
        img[9]=8'hA7; img[10]=8'h01; img[11]=8'h02;
        img[12]=op;   img[13]=8'h03;
        img[14]=8'h82; img[15]=8'h00; img[16]=8'h00;
        img[17]=8'h47; img[18]=8'h00; img[19]=8'h01;
        img[20]=8'h82; img[21]=8'h00; img[22]=8'h01;
        img[23]=8'h47; img[24]=8'h00; img[25]=8'h01;
        run_prog(26);
        check(ncap == 1 && cap[0] == e, "R4 R6 compare and branch vector", cap[0], e);
      end
    end

    img[0]=8'h82; img[1]=8'h01; img[2]=8'd1;
    img[3]=8'h82; img[4]=8'h02; img[5]=8'd2;
    img[6]=8'h82; img[7]=8'h03; img[8]=8'd20;
    img[9]=8'hA7; img[10]=8'h01; img[11]=8'h02;
    img[12]=8'hA7; img[13]=8'h01; img[14]=8'h01;
    img[15]=8'h55; img[16]=8'h03;
    img[17]=8'h47; img[18]=8'h00; img[19]=8'h01;
    img[20]=8'h82; img[21]=8'h00; img[22]=8'h01;
    img[23]=8'h47; img[24]=8'h00; img[25]=8'h01;
    run_prog(26);
    check(ncap == 1 && cap[0] == 1, "R10 second CMP overrides flag", cap[0], 1);

    img[0]=8'h82; img[1]=8'h04; img[2]=8'd10;
    img[3]=8'h54; img[4]=8'h04;
    img[5]=8'h82; img[6]=8'h00; img[7]=8'hAA;
    img[8]=8'h47; img[9]=8'h00;
    img[10]=8'h82; img[11]=8'h00; img[12]=8'hBB;
    img[13]=8'h47; img[14]=8'h00; img[15]=8'h01;
    run_prog(16);
    check(ncap == 1 && cap[0] == 8'hBB, "R5 JMP target", cap[0], 8'hBB);

    img[0]=8'h82; img[1]=8'h00; img[2]=8'd5;
    img[3]=8'h01;
    img[4]=8'h47; img[5]=8'h00;
    run_prog(6);
    repeat (20) @(negedge clk);
    check(ncap == 0, "R7 nothing after HLT", ncap, 0);
    check(halted && !illegal, "R7 HLT not illegal", illegal, 0);

    img[0]=8'h82; img[1]=8'h00; img[2]=8'd9;
    img[3]=8'h47; img[4]=8'h00;
    img[5]=8'hFF;
    img[6]=8'h47; img[7]=8'h00;
    run_prog(8);
    check(ncap == 1 && cap[0] == 8'd9, "R8 prints before illegal", ncap, 1);
    check(illegal && halted, "R8 illegal raised", illegal, 1);
    repeat (10) @(negedge clk);
    check(illegal && halted && ncap == 1, "R8 illegal sticky", illegal, 1);

    img[0]=8'h82; img[1]=8'h01; img[2]=8'h33;
    img[3]=8'h45; img[4]=8'h01;
    img[5]=8'h82; img[6]=8'h01; img[7]=8'h00;
    img[8]=8'h46; img[9]=8'h02;
    img[10]=8'h47; img[11]=8'h02;
    img[12]=8'h82; img[13]=8'h03; img[14]=8'd23;
    img[15]=8'h50; img[16]=8'h03;
    img[17]=8'h82; img[18]=8'h00; img[19]=8'h5A;
    img[20]=8'h47; img[21]=8'h00; img[22]=8'h01;
    img[23]=8'h82; img[24]=8'h04; img[25]=8'h77;
    img[26]=8'h47; img[27]=8'h04; img[28]=8'h11;
    run_prog(29);
    check(ncap == 3, "R9 stack print count", ncap, 3);
    check(cap[0] == 8'h33, "R9 push/pop round trip", cap[0], 8'h33);
    check(cap[1] == 8'h77, "R9 call enters subroutine", cap[1], 8'h77);
    check(cap[2] == 8'h5A, "R9 return resumes after call", cap[2], 8'h5A);
    check(!illegal, "R9 stack ops not illegal", illegal, 0);

    rst_n = 1'b0;
    @(negedge clk);
    check(!halted && !illegal && !out_valid, "R1 reset clears status", {halted, illegal}, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 150000);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule